// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block connects a synchronous host to an external asynchronous static RAM of 32768 bytes. The RAM is controlled by active-low chip select, write enable and output enable lines. It has a 15-bit address and one 8-bit data bus that carries data in both directions. The host starts a transfer by pulsing a request together with an address, a write flag and write data. When the transfer ends, the controller raises a one-cycle ready pulse, and after a read it presents the captured byte.

Internally a strobe state machine moves through the setup, pulse, hold and access phases. A shared down counter times each phase. The phase lengths are parameters counted in clock cycles. With a 5 ns clock the defaults give 5 ns of address setup, a 50 ns write pulse, 5 ns of data hold and 75 ns of read access, which covers the slowest 70 ns device grade. All strobes and the data driver enable come straight from flops. During a write, the write strobe always ends before chip select. The controller's data driver and the RAM's output enable are never active at the same time.

Top module: `async_sram_ctrl`

## Requirements
- R1: During and after reset, with no request pending, chip select, write enable and output enable are all high (inactive), ready is low and the read data register is zero.
- R2: A request with `we_i`=1 starts a write, and `we_i`=0 starts a read. For a write, chip select goes low in the first cycle after the accepting edge. Write enable goes low SETUP_CYC cycles later and stays low for PULSE_CYC cycles. Output enable stays high for the whole write.
- R3: Write enable returns high one cycle before chip select does. The address and the driven write data then stay unchanged for HOLD_CYC more cycles with chip select high.
- R4: A read drives chip select low with write enable high. Output enable goes low SETUP_CYC cycles later and stays low for ACCESS_CYC cycles. The bus is sampled on the edge that ends that window, and the sampled byte appears on `rdata_o` in the ready cycle.
- R5: `ready_o` is high for exactly one cycle per accepted request. For a write this is the cycle SETUP_CYC+PULSE_CYC+1+HOLD_CYC+1 after the accepting edge. For a read it is the cycle SETUP_CYC+ACCESS_CYC+1.
- R6: The controller drives the data bus only while output enable is high. It releases the bus at least one full cycle before output enable falls.
- R7: The RAM address is stable in every cycle in which chip select stays low.
- R8: A request is accepted only when the controller is idle, which includes the ready cycle. A request raised during a transfer is dropped and has no effect on the RAM or the strobes.
- R9: `rdata_o` holds the last read byte until the next read completes. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request pulse, taken only while idle |
| we_i | input | 1 | 1 selects a write, 0 a read |
| addr_i | input | 15 | Byte address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| sram_addr_o | output | 15 | RAM address |
| sram_cs_no | output | 1 | RAM chip select, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_dq_io | inout | 8 | Shared RAM data bus |

## Verification
Each strobe, the address, the driven data and ready are all flop outputs. Each one is therefore due in the cycle after the accepting edge, shifted by a fixed phase offset: SETUP_CYC, then PULSE_CYC, one turnaround cycle and HOLD_CYC for a write, or SETUP_CYC then ACCESS_CYC for a read. The ready pulse follows in the cycle after that.

When a request is accepted, the bench pushes one expected record for every cycle of the transfer into a queue. The bench drives inputs on the falling edge. On each later falling edge it pops one record and compares every output against it, so each value is checked in exactly the cycle it is due.

The RAM model in the bench stores data on the first rising edge of either strobe. Read-back of written bytes therefore confirms that the data was presented at the capture point.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_PULSE,
    ST_W_END,
    ST_W_HOLD,
    ST_R_SETUP,
    ST_R_ACCESS
  } state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

  function automatic strobe_t strobe_of(state_e s);
    strobe_t r;
    r = STROBE_IDLE;
    unique case (s)
      ST_W_SETUP:  r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
      ST_W_PULSE:  r = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
      ST_W_END:    r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
      ST_W_HOLD:   r = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
      ST_R_SETUP:  r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
      ST_R_ACCESS: r = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
      default:     r = STROBE_IDLE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // counter never wraps past zero
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && $past(load_i) == 1'b0 && $past(cnt_q) == '0) |-> (cnt_q == '0));

endmodule

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 10,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             expired_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             cs_no,
  output logic             we_no,
  output logic             oe_no,
  output logic             drv_o
);

  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] ACCESS_LD = CNT_W'(ACCESS_CYC - 1);

  state_e  st_q, st_d;
  strobe_t stb_q;
  logic    ready_d, ready_q;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    ready_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        accept_o   = 1'b1;
        load_o     = 1'b1;
        load_val_o = SETUP_LD;
        st_d       = we_i ? ST_W_SETUP : ST_R_SETUP;
      end
      ST_W_SETUP: if (expired_i) begin
        load_o     = 1'b1;
        load_val_o = PULSE_LD;
        st_d       = ST_W_PULSE;
      end
      ST_W_PULSE: if (expired_i) st_d = ST_W_END;
      ST_W_END: begin
        load_o     = 1'b1;
        load_val_o = HOLD_LD;
        st_d       = ST_W_HOLD;
      end
      ST_W_HOLD: if (expired_i) begin
        ready_d = 1'b1;
        st_d    = ST_IDLE;
      end
      ST_R_SETUP: if (expired_i) begin
        load_o     = 1'b1;
        load_val_o = ACCESS_LD;
        st_d       = ST_R_ACCESS;
      end
      ST_R_ACCESS: if (expired_i) begin
        capture_o = 1'b1;
        ready_d   = 1'b1;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes registered from the next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      stb_q   <= STROBE_IDLE;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      stb_q   <= strobe_of(st_d);
      ready_q <= ready_d;
    end
  end

  assign cs_no   = stb_q.cs_n;
  assign we_no   = stb_q.we_n;
  assign oe_no   = stb_q.oe_n;
  assign drv_o   = stb_q.drv;
  assign ready_o = ready_q;

  a_r2_we_inside_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !cs_no);
  a_r2_oe_high_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> oe_no);
  a_r3_we_ends_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> !cs_no);
  a_r6_no_drive_with_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_o |-> oe_no);
  a_r6_turnaround_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_no) |-> !$past(drv_o));
  a_r5_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  a_r8_accept_when_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (cs_no && we_no && oe_no && !drv_o));

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_in_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_out_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_in_i;
  end

  assign addr_o   = addr_q;
  assign dq_out_o = wdata_q;
  assign rdata_o  = rdata_q;

  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(capture_i) |-> $stable(rdata_q));

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 10,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  inout  wire  [DATA_W-1:0] sram_dq_io
);

  localparam int MAX_AB  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_CD  = (HOLD_CYC > ACCESS_CYC) ? HOLD_CYC : ACCESS_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic             load, expired, accept, capture, drv;
  logic [CNT_W-1:0] load_val;
  logic [DATA_W-1:0] dq_out;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  sram_strobe_fsm #(
    .CNT_W      (CNT_W),
    .SETUP_CYC  (SETUP_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .ACCESS_CYC (ACCESS_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .expired_i  (expired),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ready_o    (ready_o),
    .cs_no      (sram_cs_no),
    .we_no      (sram_we_no),
    .oe_no      (sram_oe_no),
    .drv_o      (drv)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .dq_in_i   (sram_dq_io),
    .addr_o    (sram_addr_o),
    .dq_out_o  (dq_out),
    .rdata_o   (rdata_o)
  );

  assign sram_dq_io = drv ? dq_out : {DATA_W{1'bz}};

  a_r7_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_no && $past(!sram_cs_no)) |-> $stable(sram_addr_o));
  a_r3_wdata_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv && $past(drv)) |-> ($stable(dq_out) && $stable(sram_addr_o)));

endmodule

// File: tb/tb_async_sram_ctrl.sv
`timescale 1ns/1ps
module tb_async_sram_ctrl;

  localparam int S = 1, P = 10, H = 1, A = 15;

  typedef struct packed {
    bit cs, we, oe, drv, rdy, rd;
    logic [14:0] a;
    logic [7:0]  d;
  } exp_t;

  localparam exp_t IDLE_E = '{cs: 1'b1, we: 1'b1, oe: 1'b1, drv: 1'b0, rdy: 1'b0, rd: 1'b0, a: '0, d: '0};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [14:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ready_o;
  logic [7:0]  rdata_o;
  logic [14:0] sram_addr_o;
  logic        sram_cs_no, sram_we_no, sram_oe_no;
  wire  [7:0]  sram_dq_io;

  int   checks = 0, errors = 0;
  bit   done = 1'b0, live = 1'b0;
  exp_t q[$];
  logic [7:0] exp_rdata = '0;
  logic [7:0] ram [0:32767];
  logic [7:0] ref_mem [0:32767];

  always #2.5 clk_i = ~clk_i;

  async_sram_ctrl #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .ACCESS_CYC(A)) dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .ready_o, .rdata_o,
    .sram_addr_o, .sram_cs_no, .sram_we_no, .sram_oe_no, .sram_dq_io
  );

  // RAM model: stores on the first strobe to rise, drives only when reading
  wire wr_end = sram_cs_no | sram_we_no;
  always @(posedge wr_end) if (live) ram[sram_addr_o] <= sram_dq_io;
  assign sram_dq_io = (!sram_cs_no && sram_we_no && !sram_oe_no) ? ram[sram_addr_o] : 8'bz;

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic compare();
    exp_t e;
    e = (q.size() > 0) ? q.pop_front() : IDLE_E;
    if (e.rdy && e.rd) exp_rdata = e.d;
    chk(sram_cs_no, e.cs,  "R2 cs_n");
    chk(sram_we_no, e.we,  "R3 we_n");
    chk(sram_oe_no, e.oe,  "R4 oe_n");
    chk(ready_o,    e.rdy, "R5 ready");
    chk(rdata_o,    exp_rdata, "R9 rdata");
    if (!e.cs || e.drv) chk(sram_addr_o, e.a, "R7 addr");
    if (e.drv) chk(sram_dq_io, e.d, "R3 dq write data");
  endtask

  function automatic exp_t mk(bit cs, bit we, bit oe, bit drv, bit rdy, bit rd,
                              logic [14:0] a, logic [7:0] d);
    mk = '{cs: cs, we: we, oe: oe, drv: drv, rdy: rdy, rd: rd, a: a, d: d};
  endfunction

  task automatic tick(input bit rq, input bit w, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk_i);
    compare();
    req_i = rq; we_i = w; addr_i = a; wdata_i = d;
    if (rq && q.size() == 0) begin
      if (w) begin
        for (int i = 0; i < S; i++) q.push_back(mk(0, 1, 1, 1, 0, 0, a, d));
        for (int i = 0; i < P; i++) q.push_back(mk(0, 0, 1, 1, 0, 0, a, d));
        q.push_back(mk(0, 1, 1, 1, 0, 0, a, d));
        for (int i = 0; i < H; i++) q.push_back(mk(1, 1, 1, 1, 0, 0, a, d));
        q.push_back(mk(1, 1, 1, 0, 1, 0, a, d));
        ref_mem[a] = d;
      end else begin
        for (int i = 0; i < S; i++) q.push_back(mk(0, 1, 1, 0, 0, 1, a, 8'h0));
        for (int i = 0; i < A; i++) q.push_back(mk(0, 1, 0, 0, 0, 1, a, 8'h0));
        q.push_back(mk(1, 1, 1, 0, 1, 1, a, ref_mem[a]));
      end
    end
    // a request while q is non-empty is dropped by the design (R8)
  endtask

  task automatic drain();
    while (q.size() > 0) tick(0, 0, '0, '0);
    tick(0, 0, '0, '0);
  endtask

  initial begin
    for (int i = 0; i < 32768; i++) begin
      ram[i]     = 8'(i * 7) ^ 8'h5a;
      ref_mem[i] = 8'(i * 7) ^ 8'h5a;
    end
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(sram_cs_no, 1, "R1 cs_n in reset");
    chk(sram_we_no, 1, "R1 we_n in reset");
    chk(sram_oe_no, 1, "R1 oe_n in reset");
    chk(ready_o,    0, "R1 ready in reset");
    chk(rdata_o,    0, "R1 rdata in reset");
    rst_ni = 1'b1;
    live   = 1'b1;
    repeat (2) tick(0, 0, '0, '0);

    // R2/R3: writes at the address extremes and a middle value
    tick(1, 1, 15'h0000, 8'hA5); drain();
    tick(1, 1, 15'h7FFF, 8'h3C); drain();
    tick(1, 1, 15'h1234, 8'h81); drain();

    // R4/R9: read back written data and an untouched location
    tick(1, 0, 15'h7FFF, 8'h00); drain();
    tick(1, 0, 15'h0000, 8'h00); drain();
    tick(1, 0, 15'h0020, 8'h00); drain();

    // R8: request during a write is ignored; location 0x0020 keeps its value
    tick(1, 1, 15'h0010, 8'h77);
    repeat (4) tick(1, 1, 15'h0020, 8'hEE);
    drain();
    tick(1, 0, 15'h0020, 8'h00); drain();
    tick(1, 0, 15'h0010, 8'h00);

    // R5/R6: back-to-back, next request issued in the ready cycle
    while (q.size() > 1) tick(0, 0, '0, '0);
    tick(1, 1, 15'h1234, 8'h4B);
    while (q.size() > 1) tick(0, 0, '0, '0);
    tick(1, 0, 15'h1234, 8'h00);
    drain();
    // R9: a write must not disturb rdata_o
    tick(1, 1, 15'h0001, 8'hC3); drain();
    tick(1, 0, 15'h0001, 8'h00); drain();

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule